// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave side of a 1024-byte serial EEPROM. The byte array sits in on-chip RAM. A host drives chip select, serial clock and serial data in. The block decodes an 8-bit command, takes a 16-bit address and then does one of two things: it streams bytes out of the array, or it collects up to one page of bytes in a page buffer. When a collected write is closed correctly, the block commits it during an internal write window whose length in system-clock cycles is a parameter.

All pins are brought into the system clock domain through two-flop synchronizers, and the serial clock edges are found from the synchronized copy. Both clock polarities are accepted: idle-low (mode 0) and idle-high (mode 3).

The write-enable latch, block protection and status bits live in a separate protection block. This engine tells that block when an enable-set, enable-clear or status-write command completes, and which page a committed write targets. In return it receives a single permit bit and the status byte it must return.

Top module: `spi_eeprom_core`

## Requirements
- R1: The command byte 0x06 raises `wren_pulse` for one cycle, and 0x04 raises `wrdi_pulse` for one cycle. Each pulse is given only if CS rises right after exactly eight clocked bits. Any other bit count gives no pulse.
- R2: Command 0x01 followed by exactly one more byte raises `wrsr_pulse` on the CS rise, with that byte on `wrsr_data`.
- R3: Command 0x03 followed by a 16-bit address (MSB first) streams array bytes MSB first on `so`. Each bit changes only after a falling SCK edge, and the first bit comes after the falling edge that follows the last address bit.
- R4: During a read, the address advances after each byte and wraps from 0x3FF to 0x000. Address bits 15:10 are ignored.
- R5: Command 0x02 loads data bytes into the page at the given address. Only address bits 3:0 advance, so a 17th or later byte overwrites earlier bytes of the same 16-byte page. `wr_page` shows address bits 9:4.
- R6: A write commits (`wr_start` pulses) only if all of the following hold when CS rises: the rise comes right after bit 0 of a data byte, at least one data byte was sent, and `wr_permit` is high. Otherwise the array is unchanged.
- R7: After a commit, `busy` stays high for exactly WR_CYCLES system clocks, whatever CS does. The page bytes that were sent reach the array inside that window.
- R8: While `busy` is high, every command except status read (0x05) is ignored and `so_oe` stays low. A status read returns `{status_in[7:1], status_in[0] | busy}` in every byte.
- R9: `so_oe` is low after reset and within the synchronizer latency of CS going high.
- R10: After reset, no command is accepted until CS has been seen high and then low.
- R11: Reads, writes and commands behave the same in mode 0 and in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| status_in | input | 8 | Status byte from the protection block |
| wr_permit | input | 1 | Protection block allows the pending page write |
| wr_page | output | GW (6) | Page index of the latched write address |
| wr_start | output | 1 | One-cycle pulse: write window begins |
| wren_pulse | output | 1 | Enable-set command completed |
| wrdi_pulse | output | 1 | Enable-clear command completed |
| wrsr_pulse | output | 1 | Status-write command completed |
| wrsr_data | output | 8 | Byte carried by the status write |
| busy | output | 1 | Internal write window active |

## Verification
A status read can be served in the same cycles in which the commit walker writes the array, and the busy flag can drop while a status byte is being shifted. The bench starts a page commit and then, with no wait, issues a status read, an array read, a write and an enable-set. It checks that the status byte is taken whole at its first falling edge with the in-progress bit set. It also checks that the other commands leave no trace: no output enable, no pulse and no array change when read back once the window has closed.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;
  localparam logic [7:0] OPC_NONE  = 8'h00;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;

  // byte position inside one CS-low frame
  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_AHI  = 2'd1,
    PH_ALO  = 2'd2,
    PH_DATA = 2'd3
  } frame_ph_e;
endpackage

// File: rtl/spi_eep_sync.sv
module spi_eep_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_eep_array.sv
module spi_eep_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_eep_pagebuf.sv
module spi_eep_pagebuf #(
  parameter  int PAGE_BYTES = 16,
  parameter  int PAGES      = 64,
  parameter  int WR_CYCLES  = 500000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int GW = $clog2(PAGES),
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic [PW-1:0]    ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             start,
  input  logic [GW-1:0]    start_page,
  output logic             busy,
  output logic             mem_we,
  output logic [GW+PW-1:0] mem_waddr,
  output logic [7:0]       mem_wdata
);
  logic [7:0]            pg_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;
  logic [GW-1:0]         page_q;
  logic [PW-1:0]         walk;
  logic                  walking;
  logic [CW-1:0]         cnt;

  always_ff @(posedge clk) begin
    if (ld) pg_data[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst)      vld <= '0;
    else if (clr) vld <= '0;
    else if (ld)  vld[ld_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      walking   <= 1'b0;
      walk      <= '0;
      page_q    <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= CW'(WR_CYCLES - 1);
        walking <= 1'b1;
        walk    <= '0;
        page_q  <= start_page;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
        if (walking) begin
          mem_we    <= vld[walk];
          mem_waddr <= {page_q, walk};
          mem_wdata <= pg_data[walk];
          walk      <= walk + 1'b1;
          if (walk == PW'(PAGE_BYTES - 1)) walking <= 1'b0;
        end
      end
    end
  end

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R7
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R7
  we_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
endmodule

// File: rtl/spi_eeprom_core.sv
module spi_eeprom_core
  import spi_eep_pkg::*;
#(
  parameter  int MEM_BYTES  = 1024,
  parameter  int PAGE_BYTES = 16,
  parameter  int WR_CYCLES  = 500000,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int GW = AW - PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic [7:0]    status_in,
  input  logic          wr_permit,
  output logic [GW-1:0] wr_page,
  output logic          wr_start,
  output logic          wren_pulse,
  output logic          wrdi_pulse,
  output logic          wrsr_pulse,
  output logic [7:0]    wrsr_data,
  output logic          busy
);
  localparam int PAGES = MEM_BYTES / PAGE_BYTES;

  logic [2:0] syn_q;
  logic       cs_s, sck_s, si_s, cs_d, sck_d;

  spi_eep_sync #(.W(3), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, si}),
    .q   (syn_q)
  );
  assign cs_s  = syn_q[2];
  assign sck_s = syn_q[1];
  assign si_s  = syn_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  // frame state
  logic          active, ign, got_data;
  logic [2:0]    bitn;
  logic [6:0]    sh;
  logic [7:0]    op, b1, out_sh;
  frame_ph_e     phase;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] wptr;
  logic [7:0]    rd_q;

  logic          sel, sck_rise, sck_fall, cs_fall, cs_end, bdone;
  logic [7:0]    bval, out_src;
  logic [AW-1:0] addr_lo;
  logic          is_wr, out_phase, commit, pb_ld, pb_clr;

  assign sel      = active & ~cs_s;
  assign sck_rise = sel & sck_s & ~sck_d;
  assign sck_fall = sel & ~sck_s & sck_d;
  assign cs_fall  = cs_d & ~cs_s;
  assign cs_end   = active & cs_s;
  assign bdone    = sck_rise & (bitn == 3'd7);
  assign bval     = {sh, si_s};
  assign addr_lo  = {b1[AW-9:0], bval};
  assign is_wr    = (op == OPC_WRITE) & ~ign;

  assign out_phase = ~ign & (((op == OPC_READ) & (phase == PH_DATA)) |
                             ((op == OPC_RDSR) & (phase != PH_OPC)));
  assign out_src   = (op == OPC_RDSR) ? {status_in[7:1], status_in[0] | busy} : rd_q;

  assign pb_clr = bdone & is_wr & (phase == PH_ALO);
  assign pb_ld  = bdone & is_wr & (phase == PH_DATA);
  assign commit = cs_end & is_wr & (phase == PH_DATA) & got_data &
                  (bitn == 3'd0) & wr_permit;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      ign        <= 1'b0;
      got_data   <= 1'b0;
      bitn       <= '0;
      sh         <= '0;
      op         <= OPC_NONE;
      b1         <= '0;
      out_sh     <= '0;
      phase      <= PH_OPC;
      rd_addr    <= '0;
      wptr       <= '0;
      so         <= 1'b0;
      so_oe      <= 1'b0;
      wr_page    <= '0;
      wr_start   <= 1'b0;
      wren_pulse <= 1'b0;
      wrdi_pulse <= 1'b0;
      wrsr_pulse <= 1'b0;
      wrsr_data  <= '0;
    end else begin
      wren_pulse <= 1'b0;
      wrdi_pulse <= 1'b0;
      wrsr_pulse <= 1'b0;
      wr_start   <= commit;
      if (cs_fall) begin
        active   <= 1'b1;
        bitn     <= '0;
        phase    <= PH_OPC;
        op       <= OPC_NONE;
        ign      <= 1'b0;
        got_data <= 1'b0;
        so_oe    <= 1'b0;
      end else if (cs_end) begin
        active <= 1'b0;
        so_oe  <= 1'b0;
        if (!ign && bitn == 3'd0) begin
          if (op == OPC_WREN && phase == PH_AHI) wren_pulse <= 1'b1;
          if (op == OPC_WRDI && phase == PH_AHI) wrdi_pulse <= 1'b1;
          if (op == OPC_WRSR && phase == PH_ALO) begin
            wrsr_pulse <= 1'b1;
            wrsr_data  <= b1;
          end
        end
      end else begin
        if (sck_rise) begin
          sh   <= bval[6:0];
          bitn <= bitn + 1'b1;
          if (bitn == 3'd7) begin
            unique case (phase)
              PH_OPC: begin
                op    <= bval;
                ign   <= busy & (bval != OPC_RDSR);
                phase <= PH_AHI;
              end
              PH_AHI: begin
                b1    <= bval;
                phase <= PH_ALO;
              end
              PH_ALO: begin
                rd_addr <= addr_lo;
                wptr    <= addr_lo[PW-1:0];
                if (is_wr) wr_page <= addr_lo[AW-1:PW];
                phase   <= PH_DATA;
              end
              default: begin
                if (is_wr) begin
                  wptr     <= wptr + 1'b1;
                  got_data <= 1'b1;
                end
                if (op == OPC_READ) rd_addr <= rd_addr + 1'b1;
              end
            endcase
          end
        end
        if (sck_fall && out_phase) begin
          so_oe <= 1'b1;
          if (bitn == 3'd0) begin
            so     <= out_src[7];
            out_sh <= {out_src[6:0], 1'b0};
          end else begin
            so     <= out_sh[7];
            out_sh <= {out_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  spi_eep_pagebuf #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGES      (PAGES),
    .WR_CYCLES  (WR_CYCLES)
  ) u_pagebuf (
    .clk        (clk),
    .rst        (rst),
    .clr        (pb_clr),
    .ld         (pb_ld),
    .ld_idx     (wptr),
    .ld_data    (bval),
    .start      (commit),
    .start_page (wr_page),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata)
  );

  spi_eep_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_q)
  );

  // R9
  so_off_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !so_oe);
  // R1
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wren_pulse, wrdi_pulse, wrsr_pulse, wr_start}));
  // R8
  busy_status_only_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && so_oe) |-> (op == OPC_RDSR));
  // R3
  so_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));
  // R6
  commit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> !active);
endmodule

// File: tb/sim_spi_eeprom_core.sv
module sim_spi_eeprom_core;
  localparam int HP   = 6;
  localparam int WRC  = 2000;
  localparam int MEMN = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b0, sck = 1'b0, si = 1'b0;
  logic       so, so_oe, wr_start, wren_pulse, wrdi_pulse, wrsr_pulse, busy;
  logic [7:0] status_in = 8'hA4;
  logic       wr_permit = 1'b1;
  logic [5:0] wr_page;
  logic [7:0] wrsr_data;

  always #2.5 clk = ~clk;

  spi_eeprom_core #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe),
    .status_in(status_in), .wr_permit(wr_permit), .wr_page(wr_page),
    .wr_start(wr_start), .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse),
    .wrsr_pulse(wrsr_pulse), .wrsr_data(wrsr_data), .busy(busy)
  );

  int n_chk = 0, n_err = 0;
  int n_wren = 0, n_wrdi = 0, n_wrsr = 0, n_start = 0;
  int busy_run = 0, last_busy_len = 0, cs_hi_cnt = 0, oe_bad = 0;
  logic [5:0] last_page = '0;
  logic oe_seen = 1'b0;
  logic mode3 = 1'b0;
  int model [MEMN];

  // per-clock monitor against the pin-level model
  always @(posedge clk) begin
    if (!rst) begin
      if (wren_pulse) n_wren++;
      if (wrdi_pulse) n_wrdi++;
      if (wrsr_pulse) n_wrsr++;
      if (wr_start) begin n_start++; last_page = wr_page; end
      if (busy) busy_run++;
      else if (busy_run != 0) begin last_busy_len = busy_run; busy_run = 0; end
      cs_hi_cnt = cs_n ? cs_hi_cnt + 1 : 0;
      if (cs_hi_cnt > 4 && so_oe) oe_bad++;
      if (!cs_n && so_oe) oe_seen = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sck = 1'b0; si = b;
    tick(HP);
    r = so;
    sck = 1'b1;
    tick(HP);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic cs_lo();
    sck = mode3; tick(HP);
    oe_seen = 1'b0;
    cs_n = 1'b0; tick(HP);
  endtask

  task automatic cs_hi();
    if (!mode3) begin sck = 1'b0; tick(HP); end
    cs_n = 1'b1; tick(3 * HP);
  endtask

  task automatic cmd1(input logic [7:0] opc);
    logic [7:0] d;
    cs_lo(); xbyte(opc, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    cs_lo(); xbyte(8'h05, d); xbyte(8'h00, st); cs_hi();
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] seed, input int extra);
    logic [7:0] d;
    logic r;
    cs_lo();
    xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < n; k++) xbyte(seed + 8'(k * 7), d);
    for (int k = 0; k < extra; k++) bit_x(1'b1, r);
    cs_hi();
  endtask

  function automatic void apply_write(input logic [15:0] a, input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      int ad;
      ad = (int'(a[9:0]) & 10'h3F0) | ((int'(a[3:0]) + k) & 15);
      model[ad] = int'(seed + 8'(k * 7));
    end
  endfunction

  task automatic do_read(input string req, input logic [15:0] a, input int n);
    logic [7:0] d;
    cs_lo();
    xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, d);
      chk(req, 32'(d), 32'(model[(int'(a[9:0]) + k) % MEMN]));
    end
    cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    int lim = 200;
    rdsr(st);
    while (st[0] && lim > 0) begin rdsr(st); lim--; end
    chk("R7 idle", 32'(st[0]), 32'h0);
  endtask

  initial begin
    logic [7:0] st, d;
    logic r;
    int s0;
    for (int i = 0; i < MEMN; i++) model[i] = 0;
    tick(10);
    rst = 1'b0;
    tick(4);
    chk("R9 reset so_oe", 32'(so_oe), 32'h0);
    chk("R7 reset busy", 32'(busy), 32'h0);
    // R10: CS held low across reset, then a full enable-set byte
    xbyte(8'h06, d); sck = 1'b0; tick(HP); cs_n = 1'b1; tick(3 * HP);
    chk("R10 no cmd before CS fall", 32'(n_wren), 32'h0);
    // R1
    cmd1(8'h06);
    chk("R1 wren", 32'(n_wren), 32'h1);
    cmd1(8'h04);
    chk("R1 wrdi", 32'(n_wrdi), 32'h1);
    cs_lo(); xbyte(8'h06, d); bit_x(1'b0, r); cs_hi();
    chk("R1 nine bits no pulse", 32'(n_wren), 32'h1);
    // R2
    cs_lo(); xbyte(8'h01, d); xbyte(8'h8C, d); cs_hi();
    chk("R2 wrsr pulse", 32'(n_wrsr), 32'h1);
    chk("R2 wrsr data", 32'(wrsr_data), 32'h8C);
    // R5 wrap inside the page, R7 window, R8 status while busy
    do_write(16'h01FC, 6, 8'h30, 0);
    chk("R6 commit", 32'(n_start), 32'h1);
    chk("R5 page out", 32'(last_page), 32'h1F);
    rdsr(st);
    chk("R8 status while busy", 32'(st), 32'hA5);
    wait_idle();
    chk("R7 window length", 32'(last_busy_len), 32'(WRC));
    apply_write(16'h01FC, 6, 8'h30);
    do_read("R5 wrapped page", 16'h01F0, 16);
    do_write(16'h0052, 20, 8'h11, 0);
    wait_idle();
    apply_write(16'h0052, 20, 8'h11);
    do_read("R5 overwrite", 16'h0050, 16);
    // R6 discards
    s0 = n_start;
    do_write(16'h0050, 3, 8'hE0, 4);
    chk("R6 misaligned rise", 32'(n_start), 32'(s0));
    do_write(16'h0050, 0, 8'h00, 0);
    chk("R6 no data byte", 32'(n_start), 32'(s0));
    wr_permit = 1'b0;
    do_write(16'h0050, 2, 8'h77, 0);
    wr_permit = 1'b1;
    chk("R6 not permitted", 32'(n_start), 32'(s0));
    do_read("R6 array unchanged", 16'h0050, 16);
    // R4 prepare both ends of the array
    do_write(16'h03F0, 16, 8'h91, 0); wait_idle(); apply_write(16'h03F0, 16, 8'h91);
    do_write(16'h0000, 16, 8'h05, 0); wait_idle(); apply_write(16'h0000, 16, 8'h05);
    // R11 mode 3
    mode3 = 1'b1; sck = 1'b1; tick(2 * HP);
    do_read("R4 R11 wrap mode3", 16'h03FE, 5);
    do_read("R4 upper bits ignored", 16'hFC10, 2);
    cmd1(8'h06);
    chk("R11 wren mode3", 32'(n_wren), 32'h2);
    mode3 = 1'b0; sck = 1'b0; tick(2 * HP);
    // R8 commands during the window
    s0 = n_start;
    do_write(16'h0100, 4, 8'h61, 0);
    chk("R8 commit", 32'(n_start), 32'(s0 + 1));
    cs_lo(); xbyte(8'h03, d); xbyte(8'h01, d); xbyte(8'hF0, d); xbyte(8'h00, d); cs_hi();
    chk("R8 read ignored", 32'(oe_seen), 32'h0);
    do_write(16'h01F0, 1, 8'hFF, 0);
    chk("R8 write ignored", 32'(n_start), 32'(s0 + 1));
    cmd1(8'h06);
    chk("R8 wren ignored", 32'(n_wren), 32'h2);
    rdsr(st);
    chk("R8 status busy", 32'(st), 32'hA5);
    wait_idle();
    rdsr(st);
    chk("R8 status idle", 32'(st), 32'hA4);
    apply_write(16'h0100, 4, 8'h61);
    do_read("R8 array intact", 16'h01F0, 2);
    do_read("R3 read new data", 16'h0100, 4);
    chk("R9 so_oe with CS high", 32'(oe_bad), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule